// File: doc/BRIEF.md
# Program Memory Table-Access Guard

This unit sits between the table-access path and the program memory array. It decides whether a table write may proceed and whether a table read returns the stored data or a word of zeros. Program memory is split into a small boot region followed by a fixed number of equal blocks. Each region owns three protection bits: one that permits writes, one that permits reads from code outside the region, and one that permits access by an external programmer.

Each access brings the program counter of the executing instruction, the table pointer target, the direction, and a flag for whether the access comes from the CPU or from an external programmer. The decisions are combinational, so the allow flag and the gated read data appear in the same cycle as the request. The protection bits are held in a register inside the unit. A configuration write can only clear bits. An erase command issued by the external programmer is the only way to set bits again.

Top module: `ptp_table_guard`

## Requirements
- R1: With the size select low, regions are boot 0x000000–0x0001FF (region 0), then block n (region n+1, n = 0..3) spanning 0x4000 bytes from 0x000200/0x004000/0x008000/0x00C000. Addresses from 0x010000 up belong to no region and are never blocked.
- R2: With the size select high, block n spans 0x2000 bytes, so the block boundaries fall at 0x2000, 0x4000 and 0x6000. Addresses from 0x008000 up are never blocked.
- R3: An internal table write is allowed only when the target region's write bit is 1, whatever the program counter.
- R4: An internal table read whose target region's read bit is 0 still returns the memory data when the program counter lies in that same region.
- R5: An internal table read whose target region's read bit is 0 returns all zeros when the program counter lies in any other region or in no region.
- R6: Code-protect bits have no effect on internal accesses. External reads and writes are governed only by the target region's code-protect bit: zeros and refusal when it is 0.
- R7: Configuration vector layout: bit r = write bit, bit 5+r = read bit, bit 10+r = code-protect bit of region r. A configuration write ANDs its data into the stored bits and appears on the readback port after the next clock edge. A bit at 0 never returns to 1 through a write.
- R8: An erase command with the external flag set restores 1s on the next edge, to all bits when the full-erase flag is set, or to the three bits of the selected region otherwise. The same command without the external flag changes nothing. When an erase and a write occur in the same cycle, the erase is applied.
- R9: After reset all protection bits are 1.
- R10: The write allow is 0 unless a valid write is presented. Read data is zero unless a valid read is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk8k_i | input | 1 | Block size select: 0 = 16 KB blocks, 1 = 8 KB blocks |
| src_ext_i | input | 1 | Request comes from the external programmer |
| acc_valid_i | input | 1 | Table access present this cycle |
| acc_write_i | input | 1 | 1 = table write, 0 = table read |
| pc_i | input | ADDR_W | Address of the executing instruction |
| tblptr_i | input | ADDR_W | Table pointer target address |
| mem_rdata_i | input | DATA_W | Data read from the program memory array |
| wr_allow_o | output | 1 | Table write may proceed |
| rd_data_o | output | DATA_W | Read data or forced zeros |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | CFG_W | Configuration write data (ANDed in) |
| erase_i | input | 1 | Erase command |
| erase_all_i | input | 1 | 1 = full erase, 0 = single region erase |
| erase_sel_i | input | RIDX_W | Region index for a single region erase |
| cfg_q_o | output | CFG_W | Stored protection bits |

## Verification
The checker enforces a few rules on every cycle. Bits never rise without an accepted external erase. A plain write yields exactly the AND of the old bits and the write data. A full erase leaves every bit set. Outputs stay quiet without a matching valid request, and read data is either the memory word or zero. The region map, the same-region read exception, the 8 KB boundaries, and the split between internal and external rules depend on the address decode. Only the bench's directed scenarios can show these, at chosen addresses on both sides of each boundary.

// File: rtl/ptp_pkg.sv
package ptp_pkg;
  // kinds of protection bit held per region, in vector slice order
  typedef enum logic [1:0] {
    KIND_WRT  = 2'd0,
    KIND_RD   = 2'd1,
    KIND_CP   = 2'd2
  } prot_kind_e;
  localparam int KINDS = 3;
endpackage

// File: rtl/ptp_region_decode.sv
module ptp_region_decode #(
  parameter int ADDR_W     = 21,
  parameter int NBLK       = 4,
  parameter int BOOT_BYTES = 512,
  parameter int LOG_BIG    = 14,
  parameter int LOG_SMALL  = 13,
  parameter int RIDX_W     = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              small_i,
  output logic              hit_o,
  output logic [RIDX_W-1:0] idx_o
);
  logic [ADDR_W-1:0] blk;

  always_comb begin
    blk   = small_i ? (addr_i >> LOG_SMALL) : (addr_i >> LOG_BIG);
    hit_o = 1'b0;
    idx_o = '0;
    if (addr_i < ADDR_W'(BOOT_BYTES)) begin
      hit_o = 1'b1;
    end else if (blk < ADDR_W'(NBLK)) begin
      hit_o = 1'b1;
      idx_o = RIDX_W'(blk + ADDR_W'(1));
    end
  end
endmodule

// File: rtl/ptp_cfg_store.sv
module ptp_cfg_store
  import ptp_pkg::*;
#(
  parameter int NREG   = 5,
  parameter int RIDX_W = 3,
  parameter int CFG_W  = KINDS * NREG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [CFG_W-1:0]  wdata_i,
  input  logic              erase_i,
  input  logic              erase_all_i,
  input  logic [RIDX_W-1:0] erase_sel_i,
  output logic [CFG_W-1:0]  cfg_q
);
  logic [CFG_W-1:0] set_mask;
  logic [CFG_W-1:0] cfg_d;
  logic             cfg_en;

  // one set bit per kind at the selected region
  always_comb begin
    set_mask = '0;
    if (erase_all_i) begin
      set_mask = '1;
    end else if (int'(erase_sel_i) < NREG) begin
      for (int k = 0; k < KINDS; k++) begin
        set_mask[k*NREG + int'(erase_sel_i)] = 1'b1;
      end
    end
  end

  always_comb begin
    cfg_en = erase_i | we_i;
    cfg_d  = cfg_q;
    if (erase_i)   cfg_d = cfg_q | set_mask;
    else if (we_i) cfg_d = cfg_q & wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '1;
    else if (cfg_en) cfg_q <= cfg_d;
  end
endmodule

// File: rtl/ptp_access_gate.sv
module ptp_access_gate
  import ptp_pkg::*;
#(
  parameter int NREG   = 5,
  parameter int RIDX_W = 3,
  parameter int DATA_W = 8,
  parameter int CFG_W  = KINDS * NREG
) (
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              pc_hit_i,
  input  logic [RIDX_W-1:0] pc_idx_i,
  input  logic              tb_hit_i,
  input  logic [RIDX_W-1:0] tb_idx_i,
  input  logic              ext_i,
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              wr_allow_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [NREG-1:0] kind_v [KINDS];
  logic wrt_b, rd_b, cp_b, same_reg, wr_ok, rd_ok;

  for (genvar k = 0; k < KINDS; k++) begin : g_kind
    assign kind_v[k] = cfg_i[k*NREG +: NREG];
  end

  always_comb begin
    wrt_b    = kind_v[KIND_WRT][tb_idx_i];
    rd_b     = kind_v[KIND_RD][tb_idx_i];
    cp_b     = kind_v[KIND_CP][tb_idx_i];
    same_reg = pc_hit_i && (pc_idx_i == tb_idx_i);
    if (!tb_hit_i) begin
      wr_ok = 1'b1;
      rd_ok = 1'b1;
    end else if (ext_i) begin
      wr_ok = cp_b;
      rd_ok = cp_b;
    end else begin
      wr_ok = wrt_b;
      rd_ok = rd_b | same_reg;
    end
    wr_allow_o = valid_i & write_i & wr_ok;
    rd_data_o  = (valid_i & ~write_i & rd_ok) ? mem_rdata_i : '0;
  end
endmodule

// File: rtl/ptp_table_guard.sv
module ptp_table_guard
  import ptp_pkg::*;
#(
  parameter int ADDR_W     = 21,
  parameter int DATA_W     = 8,
  parameter int NBLK       = 4,
  parameter int BOOT_BYTES = 512,
  parameter int LOG_BIG    = 14,
  parameter int LOG_SMALL  = 13,
  localparam int NREG      = NBLK + 1,
  localparam int RIDX_W    = $clog2(NREG),
  localparam int CFG_W     = KINDS * NREG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk8k_i,
  input  logic              src_ext_i,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] tblptr_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              wr_allow_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              erase_i,
  input  logic              erase_all_i,
  input  logic [RIDX_W-1:0] erase_sel_i,
  output logic [CFG_W-1:0]  cfg_q_o
);
  logic              pc_hit, tb_hit;
  logic [RIDX_W-1:0] pc_idx, tb_idx;
  logic              erase_ok;

  assign erase_ok = erase_i & src_ext_i;

  ptp_region_decode #(
    .ADDR_W(ADDR_W), .NBLK(NBLK), .BOOT_BYTES(BOOT_BYTES),
    .LOG_BIG(LOG_BIG), .LOG_SMALL(LOG_SMALL), .RIDX_W(RIDX_W)
  ) u_pc_dec (
    .addr_i(pc_i), .small_i(blk8k_i), .hit_o(pc_hit), .idx_o(pc_idx)
  );

  ptp_region_decode #(
    .ADDR_W(ADDR_W), .NBLK(NBLK), .BOOT_BYTES(BOOT_BYTES),
    .LOG_BIG(LOG_BIG), .LOG_SMALL(LOG_SMALL), .RIDX_W(RIDX_W)
  ) u_tb_dec (
    .addr_i(tblptr_i), .small_i(blk8k_i), .hit_o(tb_hit), .idx_o(tb_idx)
  );

  ptp_cfg_store #(.NREG(NREG), .RIDX_W(RIDX_W), .CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .wdata_i(cfg_wdata_i),
    .erase_i(erase_ok), .erase_all_i(erase_all_i),
    .erase_sel_i(erase_sel_i), .cfg_q(cfg_q_o)
  );

  ptp_access_gate #(
    .NREG(NREG), .RIDX_W(RIDX_W), .DATA_W(DATA_W), .CFG_W(CFG_W)
  ) u_gate (
    .cfg_i(cfg_q_o), .pc_hit_i(pc_hit), .pc_idx_i(pc_idx),
    .tb_hit_i(tb_hit), .tb_idx_i(tb_idx), .ext_i(src_ext_i),
    .valid_i(acc_valid_i), .write_i(acc_write_i),
    .mem_rdata_i(mem_rdata_i), .wr_allow_o(wr_allow_o), .rd_data_o(rd_data_o)
  );
endmodule

// File: rtl/ptp_table_guard_chk.sv
module ptp_table_guard_chk #(
  parameter int DATA_W = 8,
  parameter int CFG_W  = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              src_ext_i,
  input logic              acc_valid_i,
  input logic              acc_write_i,
  input logic [DATA_W-1:0] mem_rdata_i,
  input logic              wr_allow_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              cfg_we_i,
  input logic [CFG_W-1:0]  cfg_wdata_i,
  input logic              erase_i,
  input logic              erase_all_i,
  input logic [CFG_W-1:0]  cfg_q_o
);
  // bits rise only after an accepted external erase
  assert_no_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_q_o & ~$past(cfg_q_o)) != '0) |-> $past(erase_i && src_ext_i));

  assert_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_we_i && !(erase_i && src_ext_i))
      |-> (cfg_q_o == ($past(cfg_q_o) & $past(cfg_wdata_i))));

  assert_full_erase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(erase_i && src_ext_i && erase_all_i) |-> (&cfg_q_o));

  assert_wr_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_allow_o |-> (acc_valid_i && acc_write_i));

  assert_rd_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o != '0) |-> (acc_valid_i && !acc_write_i));

  assert_rd_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o == '0) || (rd_data_o == mem_rdata_i));
endmodule

bind ptp_table_guard ptp_table_guard_chk #(.DATA_W(DATA_W), .CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_ext_i(src_ext_i), .acc_valid_i(acc_valid_i),
  .acc_write_i(acc_write_i), .mem_rdata_i(mem_rdata_i), .wr_allow_o(wr_allow_o),
  .rd_data_o(rd_data_o), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
  .erase_i(erase_i), .erase_all_i(erase_all_i), .cfg_q_o(cfg_q_o)
);

// File: tb/tb_ptp_table_guard.sv
module tb_ptp_table_guard;
  localparam int AW = 21;
  localparam int DW = 8;
  localparam int CW = 15;
  localparam logic [DW-1:0] MEMV = 8'hA5;

  logic clk = 1'b0;
  logic rst_n;
  logic blk8k, ext, valid, wr;
  logic [AW-1:0] pc, tbl;
  logic [DW-1:0] mdata;
  logic wr_allow;
  logic [DW-1:0] rdata;
  logic cfg_we;
  logic [CW-1:0] cfg_wd;
  logic er, er_all;
  logic [2:0] er_sel;
  logic [CW-1:0] cfg_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [CW-1:0] exp_cfg;

  always #4 clk = ~clk;

  ptp_table_guard dut (
    .clk(clk), .rst_n(rst_n), .blk8k_i(blk8k), .src_ext_i(ext),
    .acc_valid_i(valid), .acc_write_i(wr), .pc_i(pc), .tblptr_i(tbl),
    .mem_rdata_i(mdata), .wr_allow_o(wr_allow), .rd_data_o(rdata),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd), .erase_i(er),
    .erase_all_i(er_all), .erase_sel_i(er_sel), .cfg_q_o(cfg_q)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // present one access and sample after combinational settle
  task automatic acc(input logic x, input logic w, input logic [AW-1:0] p, input logic [AW-1:0] t);
    @(negedge clk);
    valid = 1'b1; ext = x; wr = w; pc = p; tbl = t;
    #1;
  endtask

  task automatic cfg_write(input logic [CW-1:0] d, input string req);
    @(negedge clk);
    valid = 1'b0; cfg_we = 1'b1; cfg_wd = d;
    @(negedge clk);
    cfg_we = 1'b0;
    exp_cfg = exp_cfg & d;
    #1 check(req, 32'(cfg_q), 32'(exp_cfg));
  endtask

  task automatic erase_cmd(input logic x, input logic all, input logic [2:0] sel);
    @(negedge clk);
    valid = 1'b0; er = 1'b1; ext = x; er_all = all; er_sel = sel;
    @(negedge clk);
    er = 1'b0; ext = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    #1 check("R9 reset bits", 32'(cfg_q), 32'h7FFF);
    check("R10 idle write allow", 32'(wr_allow), 0);
    check("R10 idle read data", 32'(rdata), 0);
  endtask

  task automatic t_write_protect();
    cfg_write(~(CW'(1) << 1), "R7 clear write bit block0");
    acc(0, 1, 21'h003FFE, 21'h000FFF); check("R3 write from inside", 32'(wr_allow), 0);
    acc(0, 1, 21'h008FFE, 21'h000FFF); check("R3 write from outside", 32'(wr_allow), 0);
    acc(0, 1, 21'h003FFE, 21'h004000); check("R1 block1 start writable", 32'(wr_allow), 1);
    acc(0, 1, 21'h000000, 21'h000200); check("R1 block0 start protected", 32'(wr_allow), 0);
    acc(0, 1, 21'h000000, 21'h0001FF); check("R1 boot end writable", 32'(wr_allow), 1);
    cfg_write('1, "R7 ones cannot set bits");
  endtask

  task automatic t_read_protect();
    cfg_write(~(CW'(1) << 7), "R7 clear read bit block1");
    acc(0, 0, 21'h004100, 21'h007000); check("R4 same block read", 32'(rdata), 32'(MEMV));
    acc(0, 0, 21'h004000, 21'h007FFF); check("R4 same block edges", 32'(rdata), 32'(MEMV));
    acc(0, 0, 21'h000300, 21'h007000); check("R5 read from block0", 32'(rdata), 0);
    acc(0, 0, 21'h000100, 21'h004000); check("R5 read from boot", 32'(rdata), 0);
    acc(0, 0, 21'h003FFF, 21'h004000); check("R5 read across boundary", 32'(rdata), 0);
    acc(0, 0, 21'h020000, 21'h005000); check("R5 read from unmapped pc", 32'(rdata), 0);
    acc(0, 0, 21'h008000, 21'h003FFF); check("R1 block0 readable", 32'(rdata), 32'(MEMV));
  endtask

  task automatic t_small_blocks();
    cfg_write(~(CW'(1) << 4), "R7 clear write bit block3");
    acc(0, 1, 21'h000000, 21'h00FFFF); check("R1 block3 end protected", 32'(wr_allow), 0);
    acc(0, 1, 21'h000000, 21'h010000); check("R1 beyond map open", 32'(wr_allow), 1);
    blk8k = 1'b1;
    acc(0, 0, 21'h002100, 21'h003000); check("R2 8k same block read", 32'(rdata), 32'(MEMV));
    acc(0, 0, 21'h004100, 21'h003000); check("R2 8k outside read", 32'(rdata), 0);
    acc(0, 0, 21'h004100, 21'h005000); check("R2 8k block2 open", 32'(rdata), 32'(MEMV));
    acc(0, 1, 21'h000000, 21'h001FFF); check("R2 8k block0 end", 32'(wr_allow), 0);
    acc(0, 1, 21'h000000, 21'h002000); check("R2 8k block1 start", 32'(wr_allow), 1);
    acc(0, 1, 21'h000000, 21'h007FFF); check("R2 8k block3 end", 32'(wr_allow), 0);
    acc(0, 1, 21'h000000, 21'h008000); check("R2 8k beyond map", 32'(wr_allow), 1);
    blk8k = 1'b0;
  endtask

  task automatic t_code_protect();
    cfg_write(~(CW'(1) << 13), "R7 clear cp block2");
    acc(0, 0, 21'h000000, 21'h009000); check("R6 internal ignores cp", 32'(rdata), 32'(MEMV));
    acc(0, 1, 21'h000000, 21'h009000); check("R6 internal write ignores cp", 32'(wr_allow), 1);
    acc(1, 0, 21'h000000, 21'h009000); check("R6 external read blocked", 32'(rdata), 0);
    acc(1, 1, 21'h000000, 21'h009000); check("R6 external write blocked", 32'(wr_allow), 0);
    acc(1, 0, 21'h000000, 21'h00C000); check("R6 external read block3", 32'(rdata), 32'(MEMV));
    acc(1, 1, 21'h000000, 21'h001000); check("R6 external ignores write bit", 32'(wr_allow), 1);
    acc(1, 0, 21'h000000, 21'h005000); check("R6 external ignores read bit", 32'(rdata), 32'(MEMV));
  endtask

  task automatic t_erase();
    erase_cmd(0, 0, 3'd2);
    check("R8 internal erase ignored", 32'(cfg_q), 32'(exp_cfg));
    erase_cmd(0, 1, 3'd0);
    check("R8 internal full erase ignored", 32'(cfg_q), 32'(exp_cfg));
    erase_cmd(1, 0, 3'd2);
    exp_cfg = exp_cfg | CW'((1 << 2) | (1 << 7) | (1 << 12));
    check("R8 region erase", 32'(cfg_q), 32'(exp_cfg));
    acc(0, 0, 21'h000300, 21'h007000); check("R8 read open after erase", 32'(rdata), 32'(MEMV));
    // erase beats a write in the same cycle
    @(negedge clk);
    valid = 1'b0; er = 1'b1; ext = 1'b1; er_all = 1'b1; cfg_we = 1'b1; cfg_wd = '0;
    @(negedge clk);
    er = 1'b0; ext = 1'b0; cfg_we = 1'b0;
    exp_cfg = '1;
    #1 check("R8 full erase wins", 32'(cfg_q), 32'h7FFF);
    acc(0, 1, 21'h003FFE, 21'h000FFF); check("R8 write open after erase", 32'(wr_allow), 1);
  endtask

  task automatic t_idle();
    cfg_write(~(CW'(1) << 1), "R7 reclear write bit");
    @(negedge clk);
    valid = 1'b0; ext = 1'b0; wr = 1'b1; tbl = 21'h004000;
    #1 check("R10 invalid write", 32'(wr_allow), 0);
    wr = 1'b0;
    #1 check("R10 invalid read", 32'(rdata), 0);
    valid = 1'b1; wr = 1'b1;
    #1 check("R10 read data during write", 32'(rdata), 0);
    valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; blk8k = 0; ext = 0; valid = 0; wr = 0; pc = '0; tbl = '0;
    mdata = MEMV; cfg_we = 0; cfg_wd = '0; er = 0; er_all = 0; er_sel = '0;
    exp_cfg = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_protect();
    t_read_protect();
    t_small_blocks();
    t_code_protect();
    t_erase();
    t_idle();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule